// File: doc/BRIEF.md
# Packet Memory Pointer Window

This block gives a host register bank byte access to a paged packet memory. The host loads a 16-bit pointer through two byte registers. It then reads or writes packet bytes through a four-byte data window. Each window access turns into one request on a byte-wide RAM port. The page comes from one of two external page numbers. The byte within the page is the pointer offset plus the window lane.

The pointer carries two control flags. One flag picks the page source: the head of the receive queue, or the packet-number register. The other flag makes the 11-bit offset step by one after every window access, so a run of accesses walks through the page. The control bits above the offset never change on their own. The memory, the queue logic that supplies the page numbers, and any widening of the host bus sit outside this block.

Top module: `pkt_window`

## Requirements
- R1: After reset the pointer is 0x0000, `reg_rvalid_o` is low and `mem_req_o` is low.
- R2: A write to offset 6 replaces pointer bits 7:0 and leaves bits 15:8 alone. A write to offset 7 replaces bits 15:8 and leaves bits 7:0 alone.
- R3: A read request is answered in the next cycle with `reg_rvalid_o` high. Offset 6 returns pointer bits 7:0. Offset 7 returns bits 15:8 ANDed with 0xF7, so pointer bit 11 always reads as zero.
- R4: A request at offsets 8 to 11 raises `mem_req_o` in the same cycle. The address is page × 2048 + ((pointer[10:0] + offset − 8) mod 2048), with the page in the address bits above bit 10.
- R5: When pointer bit 15 is 1 the page is `rx_head_i`. When it is 0 the page is `pkt_num_i`.
- R6: A window write drives `mem_we_o` high and puts `reg_wdata_i` on `mem_wdata_o`. A window read drives `mem_we_o` low.
- R7: For a window read, `reg_rdata_o` carries `mem_rdata_i` in the cycle after the request, with `reg_rvalid_o` high. The RAM returns its data one cycle after `mem_req_o`.
- R8: When pointer bit 14 is 1, each window access adds one to pointer bits 10:0 modulo 2048 after the access, and bits 15:11 stay the same. The next access uses the new offset.
- R9: When pointer bit 14 is 0, window accesses leave the whole pointer unchanged.
- R10: Requests at offsets 0 to 5 and 12 to 15 raise no RAM request and leave the pointer unchanged. Reads at those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Register access strobe, one access per cycle |
| reg_we_i | input | 1 | 1 for write, 0 for read |
| reg_off_i | input | 4 | Byte offset within the register bank |
| reg_wdata_i | input | 8 | Write data |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after the read request |
| reg_rdata_o | output | 8 | Read data |
| pkt_num_i | input | PW | Page chosen by the packet-number register |
| rx_head_i | input | PW | Page at the head of the receive queue |
| mem_req_o | output | 1 | RAM access request |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | AW | RAM byte address, page above offset |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, one cycle after the request |

## Verification
A pointer that drifts shows up at once in `mem_addr_o` on the next window access: a missed or extra step, a carry into bit 11, or a wrong page pick. It also shows in the byte read back through offsets 6 and 7 one cycle later. The bench walks the offset across the 2047-to-0 wrap for each setting of the two flags. It checks every address against one computed from its own model of the pointer. It then reads the bytes back and compares them with a shadow copy, so a misplaced write shows up on the first read of that location.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int OFF_W = 11;
  localparam int B_RX_SEL = 15;
  localparam int B_AUTO = 14;
  localparam logic [3:0] A_PTR_LO = 4'd6;
  localparam logic [3:0] A_PTR_HI = 4'd7;
  localparam logic [7:0] HI_MASK = 8'hF7;

  typedef enum logic [1:0] {
    RS_NONE,
    RS_PTR_LO,
    RS_PTR_HI,
    RS_MEM
  } rsrc_e;
endpackage

// File: rtl/pw_ptr_reg.sv
module pw_ptr_reg
  import pw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [7:0]  wdata_i,
  input  logic        step_i,
  output logic [15:0] ptr_o
);
  logic [15:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (wr_lo_i) begin
      ptr_q[7:0] <= wdata_i;
    end else if (wr_hi_i) begin
      ptr_q[15:8] <= wdata_i;
    end else if (step_i && ptr_q[B_AUTO]) begin
      ptr_q[OFF_W-1:0] <= ptr_q[OFF_W-1:0] + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  p_one_op_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_lo_i, wr_hi_i, step_i}));
  p_lo_keeps_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> ptr_o[15:8] == $past(ptr_o[15:8]));
  p_hi_keeps_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> ptr_o[7:0] == $past(ptr_o[7:0]));
  p_auto_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && ptr_o[B_AUTO] |=>
      ptr_o[OFF_W-1:0] == $past(ptr_o[OFF_W-1:0]) + 11'd1 &&
      ptr_o[15:OFF_W] == $past(ptr_o[15:OFF_W]));
  p_no_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !ptr_o[B_AUTO] |=> $stable(ptr_o));
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
  import pw_pkg::*;
#(
  parameter int PW = 2,
  localparam int AW = PW + OFF_W
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic             rx_sel_i,
  input  logic [1:0]       lane_i,
  input  logic [PW-1:0]    rx_head_i,
  input  logic [PW-1:0]    pkt_num_i,
  output logic [AW-1:0]    addr_o
);
  logic [PW-1:0]    page;
  logic [OFF_W-1:0] byte_off;

  always_comb begin
    page     = rx_sel_i ? rx_head_i : pkt_num_i;
    byte_off = off_i + {{(OFF_W-2){1'b0}}, lane_i};  // wraps inside the page
    addr_o   = {page, byte_off};
  end
endmodule

// File: rtl/pw_rd_ret.sv
module pw_rd_ret
  import pw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  rsrc_e       src_i,
  input  logic [15:0] ptr_i,
  input  logic [7:0]  mem_rdata_i,
  output logic        rvalid_o,
  output logic [7:0]  rdata_o
);
  logic       rvalid_q;
  rsrc_e      src_q;
  logic [7:0] byte_q;
  logic [7:0] byte_d;

  always_comb begin
    unique case (src_i)
      RS_PTR_LO: byte_d = ptr_i[7:0];
      RS_PTR_HI: byte_d = ptr_i[15:8] & HI_MASK;
      default:   byte_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      src_q    <= RS_NONE;
      byte_q   <= '0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) begin
        src_q  <= src_i;
        byte_q <= byte_d;
      end
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = (src_q == RS_MEM) ? mem_rdata_i : byte_q;

  p_rvalid_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  p_rvalid_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  p_hi_bit11_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && src_q == RS_PTR_HI |-> !rdata_o[3]);
  p_mem_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && src_q == RS_MEM |-> rdata_o == mem_rdata_i);
endmodule

// File: rtl/pkt_window.sv
module pkt_window
  import pw_pkg::*;
#(
  parameter int NUM_PACKETS = 4,
  localparam int PW = (NUM_PACKETS > 1) ? $clog2(NUM_PACKETS) : 1,
  localparam int AW = PW + OFF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_req_i,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_off_i,
  input  logic [7:0]    reg_wdata_i,
  output logic          reg_rvalid_o,
  output logic [7:0]    reg_rdata_o,
  input  logic [PW-1:0] pkt_num_i,
  input  logic [PW-1:0] rx_head_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i
);
  logic        data_hit, wr_lo, wr_hi, rd;
  logic [15:0] ptr;
  rsrc_e       src;

  always_comb begin
    data_hit = reg_req_i && (reg_off_i[3:2] == 2'b10);
    wr_lo    = reg_req_i && reg_we_i && (reg_off_i == A_PTR_LO);
    wr_hi    = reg_req_i && reg_we_i && (reg_off_i == A_PTR_HI);
    rd       = reg_req_i && !reg_we_i;
    if (data_hit)                    src = RS_MEM;
    else if (reg_off_i == A_PTR_LO)  src = RS_PTR_LO;
    else if (reg_off_i == A_PTR_HI)  src = RS_PTR_HI;
    else                             src = RS_NONE;
  end

  pw_ptr_reg u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (reg_wdata_i),
    .step_i  (data_hit),
    .ptr_o   (ptr)
  );

  pw_addr_gen #(.PW(PW)) u_addr (
    .off_i     (ptr[OFF_W-1:0]),
    .rx_sel_i  (ptr[B_RX_SEL]),
    .lane_i    (reg_off_i[1:0]),
    .rx_head_i (rx_head_i),
    .pkt_num_i (pkt_num_i),
    .addr_o    (mem_addr_o)
  );

  pw_rd_ret u_ret (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd),
    .src_i       (src),
    .ptr_i       (ptr),
    .mem_rdata_i (mem_rdata_i),
    .rvalid_o    (reg_rvalid_o),
    .rdata_o     (reg_rdata_o)
  );

  assign mem_req_o   = data_hit;
  assign mem_we_o    = data_hit && reg_we_i;
  assign mem_wdata_o = reg_wdata_i;

  p_no_stray_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_hit |=> $stable(ptr) || $past(wr_lo) || $past(wr_hi));
  p_req_in_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> reg_req_i && reg_off_i >= 4'd8 && reg_off_i <= 4'd11);
endmodule

// File: tb/pkt_window_tb.sv
module pkt_window_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int PW = 2;
  localparam int AW = PW + 11;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [3:0] off = 0;
  logic [7:0] wd = 0, rdata, m_wdata;
  logic rvalid, m_req, m_we;
  logic [AW-1:0] m_addr;
  logic [7:0] m_rdata = 0;
  logic [PW-1:0] pkt_num = 2'd1, rx_head = 2'd2;
  logic [7:0] ram [NP*2048];
  logic [7:0] shadow [NP*2048];
  int vecs = 0, errs = 0;
  bit done = 0;
  logic [15:0] exp_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_window #(.NUM_PACKETS(NP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_off_i(off), .reg_wdata_i(wd), .reg_rvalid_o(rvalid),
    .reg_rdata_o(rdata), .pkt_num_i(pkt_num), .rx_head_i(rx_head),
    .mem_req_o(m_req), .mem_we_o(m_we), .mem_addr_o(m_addr),
    .mem_wdata_o(m_wdata), .mem_rdata_i(m_rdata));

  always @(posedge clk)
    if (m_req) begin
      if (m_we) ram[m_addr] <= m_wdata;
      else m_rdata <= ram[m_addr];
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [3:0] o, input logic [7:0] d,
                     output logic c_req, output logic [AW-1:0] c_addr,
                     output logic c_we, output logic [7:0] c_wd,
                     output logic c_rv, output logic [7:0] c_rd);
    @(negedge clk);
    req = 1; we = w; off = o; wd = d;
    #1;
    c_req = m_req; c_addr = m_addr; c_we = m_we; c_wd = m_wdata;
    @(negedge clk);
    req = 0; we = 0;
    c_rv = rvalid; c_rd = rdata;
  endtask

  task automatic wr_ptr(input logic [15:0] v);
    logic q, e; logic [AW-1:0] a; logic [7:0] x, y;
    acc(1, 4'd6, v[7:0], q, a, e, x, e, y);
    acc(1, 4'd7, v[15:8], q, a, e, x, e, y);
    exp_ptr = v;
  endtask

  task automatic chk_ptr(input string tag);
    logic q, e, rv; logic [AW-1:0] a; logic [7:0] x, rd;
    acc(0, 4'd6, 8'h00, q, a, e, x, rv, rd);
    chk(tag, {rv, rd}, {1'b1, exp_ptr[7:0]});
    acc(0, 4'd7, 8'h00, q, a, e, x, rv, rd);
    chk(tag, {rv, rd}, {1'b1, exp_ptr[15:8] & 8'hF7});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic q, e, rv; logic [AW-1:0] a; logic [7:0] x, rd;
    for (int i = 0; i < NP*2048; i++) begin ram[i] = 0; shadow[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rvalid", {31'd0, rvalid}, 0);
    chk("R1 mem_req", {31'd0, m_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rvalid", {31'd0, rvalid}, 0);
    chk_ptr("R1 ptr");

    // R2 R3 byte isolation and masked high read
    wr_ptr(16'hA500);
    for (int v = 0; v < 256; v++) begin
      acc(1, 4'd6, v[7:0], q, a, e, x, rv, rd);
      exp_ptr[7:0] = v[7:0];
      chk_ptr("R2 lo write");
    end
    for (int v = 0; v < 256; v++) begin
      acc(1, 4'd7, v[7:0], q, a, e, x, rv, rd);
      exp_ptr[15:8] = v[7:0];
      chk_ptr("R3 hi write/mask");
    end

    // R4 R5 R6 R7 R8 R9: windows across the page wrap, each flag combination
    for (int cfg = 0; cfg < 4; cfg++) begin
      logic sel, aut; logic [15:0] base; logic [10:0] o;
      logic [PW-1:0] pg;
      int ea;
      sel = cfg[1]; aut = cfg[0];
      pkt_num = 2'(cfg); rx_head = 2'(3 - cfg);
      pg = sel ? rx_head : pkt_num;
      base = {sel, aut, 3'b011, 11'd2043};
      for (int pass = 0; pass < 2; pass++) begin
        wr_ptr(base);
        o = 11'd2043;
        for (int i = 0; i < 12; i++) begin
          logic [7:0] d;
          d = 8'(cfg * 37 + i * 11 + 5);
          ea = int'(pg) * 2048 + int'(11'(o + 11'(i % 4)));
          if (pass == 0) begin
            acc(1, 4'(8 + i % 4), d, q, a, e, x, rv, rd);
            shadow[ea] = d;
            chk("R4 addr", {19'd0, a}, ea);
            chk("R6 we/data", {23'd0, q, e, x}, {23'd0, 2'b11, d});
            chk("R5 page", {30'd0, a[AW-1:11]}, {30'd0, pg});
          end else begin
            acc(0, 4'(8 + i % 4), 8'h00, q, a, e, x, rv, rd);
            chk("R4 rd addr", {19'd0, a}, ea);
            chk("R6 read we", {30'd0, q, e}, 2'b10);
            chk("R7 data", {23'd0, rv, rd}, {23'd0, 1'b1, shadow[ea]});
          end
          if (aut) o = o + 11'd1;
        end
        exp_ptr = {base[15:11], o};
        chk_ptr(aut ? "R8 step" : "R9 hold");
      end
    end

    // R10 other offsets
    wr_ptr(16'h4123);
    for (int k = 0; k < 16; k++) begin
      if (k >= 6 && k <= 11) continue;
      acc(1, 4'(k), 8'hFF, q, a, e, x, rv, rd);
      chk("R10 no req", {31'd0, q}, 0);
      acc(0, 4'(k), 8'h00, q, a, e, x, rv, rd);
      chk("R10 read zero", {23'd0, q, rv, rd}, {23'd0, 2'b01, 8'h00});
    end
    chk_ptr("R10 ptr kept");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule